// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time as seven fields: second, minute, hour, weekday, day of month, month and a two-digit year counted from a base year. Time is held in binary counters. Once per second, and only while the oscillator-select field holds the run code, the counters step forward with full carry from seconds up to the year. February's length follows the Gregorian leap rule.

After each step, a short update window follows. Its length is counted in ticks of a slower reference clock. At the end of the window the counters are copied into host-visible registers. The copy is written as two-digit BCD or plain binary, and the hour as 24-hour or as 12-hour with a PM flag. The control inputs choose both formats. The host writes a field by giving a field select and data. The written value is decoded with the same format rules and loaded into the counters, unless the set-mode inhibit is high. While set mode is high, the visible registers stay frozen. Writes land only in the visible registers, and they are loaded into the counters when set mode drops.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the visible fields read second 0x00, minute 0x00, hour 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00, and uip and upd_done are low.
- R2: A sec_tick starts a step and an update window only when osc_sel equals 3'b010. For any other code the tick is dropped: no field changes and uip stays low.
- R3: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0 and carry into the day.
- R4: At day rollover the weekday steps 1..7 and wraps to 1. The day of month wraps to 1 after the month's last day and advances the month. The month wraps from 12 to 1 and advances the year.
- R5: February has 29 days when the full year (base year plus year field) is divisible by 4 and either not by 100 or by 400. Otherwise it has 28 days.
- R6: With bin_mode=0 every field is read and written as two BCD digits (high digit in bits 7:4). With bin_mode=1 every field is plain binary. The visible registers take the new format at the next refresh.
- R7: With h24_mode=0 the hour field holds hour mod 12 in bits 6:0, and bit 7 is set for hours 12..23. A written hour with bit 7 set means hour plus 12.
- R8: While set_mode is high, refreshes leave the visible registers unchanged and a field write only updates its visible register. When set_mode falls, all visible fields are decoded and loaded into the counters.
- R9: uip rises on the clock after an accepted sec_tick unless set_mode is high. It stays high for UPD_TICKS slow_tick pulses. On the last one, uip clears, the visible registers refresh, and upd_done is high for exactly one cycle.
- R10: A month value outside 1..12 is given a 31-day length.
- R11: The year field wraps from 99 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| slow_tick | input | 1 | One-cycle pulse per slow reference tick (about 32 kHz) |
| osc_sel | input | 3 | Oscillator select; 3'b010 lets time run |
| set_mode | input | 1 | Inhibits refresh and defers write loading |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select: 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year |
| wr_data | input | 8 | Field write data |
| sec_q | output | 8 | Visible seconds |
| min_q | output | 8 | Visible minutes |
| hour_q | output | 8 | Visible hour |
| wday_q | output | 8 | Visible weekday |
| mday_q | output | 8 | Visible day of month |
| month_q | output | 8 | Visible month |
| year_q | output | 8 | Visible year |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle update-ended pulse |

## Verification
The properties assume that sec_tick never arrives while an update window is still open. They also assume slow_tick pulses are one cycle wide, and that set_mode and wr_en are driven well away from reset release. The bench keeps these conditions. Every second is issued as one sec_tick pulse followed by exactly UPD_TICKS separated slow_tick pulses, so the window always closes before the next tick. Writes and mode changes occur only between complete seconds.

// File: rtl/rtc_cal_pkg.sv
// Shared types and format helpers for the calendar counter.
// Assumes 8-bit field registers; BCD helpers are only meaningful for 0..99.
package rtc_cal_pkg;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6
    } field_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_t;

    // binary value -> register form
    function automatic logic [7:0] to_reg(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return bin ? v : {tens[3:0], ones[3:0]};
    endfunction

    // register form -> binary value
    function automatic logic [7:0] from_reg(input logic [7:0] r, input logic bin);
        return bin ? r : ({4'd0, r[7:4]} * 8'd10 + {4'd0, r[3:0]});
    endfunction

    // binary hour 0..23 -> register form in the chosen hour style
    function automatic logic [7:0] enc_hour(input logic [7:0] h, input logic bin, input logic h24);
        if (h24) return to_reg(h, bin);
        return to_reg(h % 8'd12, bin) | ((h >= 8'd12) ? 8'h80 : 8'h00);
    endfunction

    // register form -> binary hour; PM flag adds twelve in 12-hour style
    function automatic logic [7:0] dec_hour(input logic [7:0] r, input logic bin, input logic h24);
        logic [7:0] v;
        v = from_reg({1'b0, r[6:0]}, bin);
        if (!h24 && r[7]) v = v + 8'd12;
        return v;
    endfunction

    function automatic logic is_leap(input int unsigned y);
        return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
    endfunction

    // days in a 1-based month; unknown months get 31
    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
        case (mon)
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            8'd2:                    return leap ? 8'd29 : 8'd28;
            default:                 return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_upd_seq.sv
// Update sequencer: accepts a second tick while the oscillator runs,
// issues one step pulse, then holds a window of UPD_TICKS slow ticks and
// ends it with a refresh pulse. Assumes no new second tick arrives while
// the window is open (such a tick is dropped).
module rtc_upd_seq #(
    parameter int UPD_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic slow_tick,
    input  logic osc_run,
    input  logic set_mode,
    output logic step,
    output logic refresh,
    output logic uip
);
    localparam int CW = (UPD_TICKS > 1) ? $clog2(UPD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(UPD_TICKS - 1);

    logic          busy;
    logic [CW-1:0] cnt;

    assign step    = sec_tick && osc_run && !busy;
    assign refresh = busy && slow_tick && (cnt == LAST);

    // window state: open on step, count slow ticks, close on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            uip  <= 1'b0;
        end else if (step) begin
            busy <= 1'b1;
            cnt  <= '0;
            uip  <= !set_mode;
        end else if (busy && slow_tick) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                uip  <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_cal_core.sv
// Binary calendar counters. Steps one second with full carry, or loads a
// complete decoded time (load wins over step). Year is an offset 0..YEAR_MOD-1
// from BASE_YEAR, used for the leap rule.
module rtc_cal_core
    import rtc_cal_pkg::*;
#(
    parameter int BASE_YEAR = 2000,
    parameter int YEAR_MOD  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  cal_t load_val,
    output cal_t now
);
    localparam logic [7:0] YEAR_LAST = 8'(YEAR_MOD - 1);

    cal_t       nxt;
    logic       leap;
    logic [7:0] mlen;

    assign leap = is_leap(int'(BASE_YEAR) + int'(now.year));
    assign mlen = month_len(now.mon, leap);

    // next-second value with carries from seconds to year
    always_comb begin
        nxt = now;
        if (now.sec >= 8'd59) begin
            nxt.sec = 8'd0;
            if (now.min >= 8'd59) begin
                nxt.min = 8'd0;
                if (now.hour >= 8'd23) begin
                    nxt.hour = 8'd0;
                    nxt.wday = (now.wday >= 8'd7) ? 8'd1 : now.wday + 8'd1;
                    if (now.mday >= mlen) begin
                        nxt.mday = 8'd1;
                        if (now.mon >= 8'd12) begin
                            nxt.mon  = 8'd1;
                            nxt.year = (now.year >= YEAR_LAST) ? 8'd0 : now.year + 8'd1;
                        end else begin
                            nxt.mon = now.mon + 8'd1;
                        end
                    end else begin
                        nxt.mday = now.mday + 8'd1;
                    end
                end else begin
                    nxt.hour = now.hour + 8'd1;
                end
            end else begin
                nxt.min = now.min + 8'd1;
            end
        end else begin
            nxt.sec = now.sec + 8'd1;
        end
    end

    // counter register: reset to day one, load or step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd1,
                     mday: 8'd1, mon: 8'd1, year: 8'd0};
        end else if (load) begin
            now <= load_val;
        end else if (step) begin
            now <= nxt;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
// Calendar counter top: host-visible field registers in BCD or binary and
// 12/24-hour form, refreshed from the binary counters at the end of each
// update window. Assumes writes and mode changes do not coincide with a
// refresh; a write in the same cycle overrides its refreshed field.
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int         BASE_YEAR    = 2000,
    parameter int         YEAR_MOD     = 100,
    parameter int         UPD_TICKS    = 8,
    parameter logic [2:0] OSC_RUN_CODE = 3'b010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       slow_tick,
    input  logic [2:0] osc_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic [7:0] wday_q,
    output logic [7:0] mday_q,
    output logic [7:0] month_q,
    output logic [7:0] year_q,
    output logic       uip,
    output logic       upd_done
);
    cal_t vis, vis_base, vis_nxt, merged, decoded, encoded, now;
    logic step, refresh, load, set_q;

    rtc_upd_seq #(.UPD_TICKS(UPD_TICKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .slow_tick(slow_tick),
        .osc_run  (osc_sel == OSC_RUN_CODE),
        .set_mode (set_mode),
        .step     (step),
        .refresh  (refresh),
        .uip      (uip)
    );

    rtc_cal_core #(.BASE_YEAR(BASE_YEAR), .YEAR_MOD(YEAR_MOD)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .load    (load),
        .load_val(decoded),
        .now     (now)
    );

    // apply a field write on top of a given register image
    function automatic cal_t put_field(input cal_t c, input logic en,
                                       input logic [2:0] sel, input logic [7:0] d);
        cal_t r;
        r = c;
        if (en) begin
            case (field_e'(sel))
                FLD_SEC:  r.sec  = d;
                FLD_MIN:  r.min  = d;
                FLD_HOUR: r.hour = d;
                FLD_WDAY: r.wday = d;
                FLD_MDAY: r.mday = d;
                FLD_MON:  r.mon  = d;
                FLD_YEAR: r.year = d;
                default:  r = c;
            endcase
        end
        return r;
    endfunction

    // decode the visible image (with any write) into binary counters
    always_comb begin
        merged       = put_field(vis, wr_en, wr_sel, wr_data);
        decoded.sec  = from_reg(merged.sec, bin_mode);
        decoded.min  = from_reg(merged.min, bin_mode);
        decoded.hour = dec_hour(merged.hour, bin_mode, h24_mode);
        decoded.wday = from_reg(merged.wday, bin_mode);
        decoded.mday = from_reg(merged.mday, bin_mode);
        decoded.mon  = from_reg(merged.mon, bin_mode);
        decoded.year = from_reg(merged.year, bin_mode);
    end

    // encode the counters into the visible register format
    always_comb begin
        encoded.sec  = to_reg(now.sec, bin_mode);
        encoded.min  = to_reg(now.min, bin_mode);
        encoded.hour = enc_hour(now.hour, bin_mode, h24_mode);
        encoded.wday = to_reg(now.wday, bin_mode);
        encoded.mday = to_reg(now.mday, bin_mode);
        encoded.mon  = to_reg(now.mon, bin_mode);
        encoded.year = to_reg(now.year, bin_mode);
    end

    // load counters on a write outside set mode, or when set mode drops
    assign load = (wr_en && !set_mode) || (set_q && !set_mode);

    // next visible image: refresh outside set mode, then the write
    always_comb begin
        vis_base = (refresh && !set_mode) ? encoded : vis;
        vis_nxt  = put_field(vis_base, wr_en, wr_sel, wr_data);
    end

    // visible registers, set-mode history and update-ended pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis      <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                          mday: 8'h01, mon: 8'h01, year: 8'h00};
            set_q    <= 1'b0;
            upd_done <= 1'b0;
        end else begin
            vis      <= vis_nxt;
            set_q    <= set_mode;
            upd_done <= refresh;
        end
    end

    assign sec_q   = vis.sec;
    assign min_q   = vis.min;
    assign hour_q  = vis.hour;
    assign wday_q  = vis.wday;
    assign mday_q  = vis.mday;
    assign month_q = vis.mon;
    assign year_q  = vis.year;
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for the calendar counter, bound to every instance.
module rtc_calendar_chk #(
    parameter logic [2:0] OSC_RUN_CODE = 3'b010
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic [2:0] osc_sel,
    input logic       set_mode,
    input logic       wr_en,
    input logic [7:0] sec_q,
    input logic [7:0] hour_q,
    input logic       uip,
    input logic       upd_done
);
    AST_OSC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && osc_sel != OSC_RUN_CODE && !uip) |=> !uip); // R2

    AST_SET_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_mode) && !$past(wr_en)) |-> ($stable(sec_q) && $stable(hour_q))); // R8

    AST_UIP_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> ($past(sec_tick) && !$past(set_mode))); // R9

    AST_DONE_CLEARS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> !uip); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done); // R9
endmodule

bind rtc_calendar rtc_calendar_chk #(.OSC_RUN_CODE(OSC_RUN_CODE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec_tick(sec_tick),
    .osc_sel (osc_sel),
    .set_mode(set_mode),
    .wr_en   (wr_en),
    .sec_q   (sec_q),
    .hour_q  (hour_q),
    .uip     (uip),
    .upd_done(upd_done)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
    localparam int CLK_PERIOD = 10;
    localparam int UPD        = 8;
    localparam int NVEC       = 10;

    // {start sec,min,hour,wday,mday,mon,year , expected after one second} in BCD 24h
    localparam logic [111:0] VEC [NVEC] = '{
        {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00},
        {56'h59_00_00_01_01_01_00, 56'h00_01_00_01_01_01_00},
        {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},
        {56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23},
        {56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24},
        {56'h59_59_23_03_29_02_24, 56'h00_00_00_04_01_03_24},
        {56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00},
        {56'h59_59_23_02_30_04_23, 56'h00_00_00_03_01_05_23},
        {56'h59_59_23_02_30_13_23, 56'h00_00_00_03_31_13_23},
        {56'h59_59_09_05_15_06_50, 56'h00_00_10_05_15_06_50}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic sec_tick = 0, slow_tick = 0, set_mode = 0, bin_mode = 0, h24_mode = 1, wr_en = 0;
    logic [2:0] osc_sel = 3'b010, wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, month_q, year_q;
    logic uip, upd_done;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .slow_tick(slow_tick),
        .osc_sel(osc_sel), .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .wday_q(wday_q),
        .mday_q(mday_q), .month_q(month_q), .year_q(year_q),
        .uip(uip), .upd_done(upd_done)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 9: return "R3";
            2:       return "R4 R11";
            3, 4, 5, 6: return "R5";
            7:       return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic slow_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1; @(negedge clk);
            slow_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic one_second();
        sec_tick = 1'b1; @(negedge clk);
        sec_tick = 1'b0;
        slow_pulses(UPD);
    endtask

    task automatic load_all(input logic [55:0] t);
        for (int f = 0; f < 7; f++) wr(3'(f), t[55 - 8*f -: 8]);
    endtask

    function automatic logic [55:0] fields();
        return {sec_q, min_q, hour_q, wday_q, mday_q, month_q, year_q};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fields", {8'h0, fields()}, {8'h0, 56'h00_00_00_01_01_01_00});
        chk("R1 flags", {62'd0, uip, upd_done}, 64'd0);

        // table walk: BCD 24-hour rollovers
        for (int v = 0; v < NVEC; v++) begin
            load_all(VEC[v][111:56]);
            one_second();
            chk(vec_tag(v), {8'h0, fields()}, {8'h0, VEC[v][55:0]});
        end

        // R9 window timing
        load_all(56'h05_00_00_01_01_01_00);
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        chk("R9 uip raised", {63'd0, uip}, 64'd1);
        slow_pulses(UPD - 1);
        chk("R9 uip held, no refresh", {54'd0, uip, upd_done, sec_q}, {54'd0, 1'b1, 1'b0, 8'h05});
        slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
        chk("R9 end of window", {54'd0, uip, upd_done, sec_q}, {54'd0, 1'b0, 1'b1, 8'h06});
        @(negedge clk);
        chk("R9 pulse one cycle", {63'd0, upd_done}, 64'd0);

        // R2 oscillator gate
        wr(3'd0, 8'h20);
        osc_sel = 3'b110;
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        chk("R2 no uip when stopped", {63'd0, uip}, 64'd0);
        slow_pulses(UPD);
        chk("R2 seconds held", {56'd0, sec_q}, {56'd0, 8'h20});
        osc_sel = 3'b010;
        one_second();
        chk("R2 runs again", {56'd0, sec_q}, {56'd0, 8'h21});

        // R6 binary mode
        bin_mode = 1'b1;
        wr(3'd0, 8'h3B); wr(3'd1, 8'h0A); wr(3'd2, 8'h05);
        one_second();
        chk("R6 binary carry", {40'd0, sec_q, min_q, hour_q}, {40'd0, 24'h00_0B_05});
        bin_mode = 1'b0;
        one_second();
        chk("R6 back to BCD", {48'd0, sec_q, min_q}, {48'd0, 16'h01_11});

        // R7 12-hour mode
        h24_mode = 1'b0;
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h81);
        one_second();
        chk("R7 1PM to 2PM", {56'd0, hour_q}, {56'd0, 8'h82});
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h91); wr(3'd3, 8'h04);
        one_second();
        chk("R7 11PM to midnight", {48'd0, hour_q, wday_q}, {48'd0, 16'h00_05});
        wr(3'd0, 8'h00); wr(3'd2, 8'h11);
        one_second();
        chk("R7 AM hour kept", {48'd0, hour_q, sec_q}, {48'd0, 16'h11_01});
        h24_mode = 1'b1;

        // R8 set mode
        wr(3'd0, 8'h10);
        set_mode = 1'b1;
        @(negedge clk);
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        chk("R8 uip stays low in set", {63'd0, uip}, 64'd0);
        slow_pulses(UPD - 1);
        slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
        chk("R8 pulse yet frozen", {55'd0, upd_done, sec_q}, {55'd0, 1'b1, 8'h10});
        @(negedge clk);
        wr(3'd0, 8'h30);
        chk("R8 write visible", {56'd0, sec_q}, {56'd0, 8'h30});
        one_second();
        chk("R8 still frozen", {56'd0, sec_q}, {56'd0, 8'h30});
        set_mode = 1'b0;
        @(negedge clk);
        one_second();
        chk("R8 deferred load", {56'd0, sec_q}, {56'd0, 8'h31});

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule